// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves an address-translation miss by reading a two-level translation table from memory. A request carries a 32-bit virtual address and a read/write flag. The frame number of the top-level table (the directory) comes from a root input that is sampled when the request is accepted. The walker reads the directory word and then, if needed, the second-level word. It stops early when an entry is marked not present, or when a directory entry maps a 4 MB region directly. On a successful walk it returns the physical address and the final entry, ready to fill a translation cache.

On the way, the walker sets the accessed flag in every entry it uses. It also sets the dirty flag in the final entry when the access is a write. Each flag update is written back to the word it came from, and only when a flag bit actually changes. Memory is reached through one request channel with a valid/ready handshake and a separate read-response strobe, with at most one request outstanding. The global, cache-disable, write-through, user/supervisor and read/write bits are carried into the result without being interpreted.

Top module: `ptw_walker`

## Requirements
- R1: The first access of a walk is a read at `{dir_root_pfn, vaddr[31:22], 2'b00}`.
- R2: When the directory entry is present (bit 0 = 1) and bit 7 = 0, the next read is at `{dir_entry[31:12], vaddr[21:12], 2'b00}`.
- R3: An entry with bit 0 = 0 at either level ends the walk with `fault` = 1, `fill_paddr` = 0 and `fill_entry` equal to the word that was read. No further memory access follows.
- R4: A walk that ends at a present second-level entry returns `fill_paddr = {entry[31:12], vaddr[11:0]}`.
- R5: A present directory entry with bit 7 = 1 ends the walk without a second-level read. The walk returns `fill_large` = 1 and `fill_paddr = {dir_entry[31:22], vaddr[21:0]}`.
- R6: Bit 5 (accessed) is set in every entry the walk uses, on reads and on writes. When the bit was clear, the updated word is written back to the address it was read from.
- R7: On a write access, bit 6 (dirty) is set in the final entry and written back in the same way. A pointing directory entry never receives bit 6.
- R8: No write-back is issued for an entry whose required flags are already set.
- R9: `fill_entry` is the final entry with only bits 5 and 6 possibly changed. Bits 8, 4, 3, 2 and 1 pass through unchanged.
- R10: `done` is a single-cycle pulse. `fault`, `fill_large`, `fill_paddr` and `fill_entry` change only on the edge that raises `done`.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and all its fields hold steady.
- R12: `start_ready` is high only while the walker is idle and has no memory request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Walk request |
| start_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| start_vaddr | input | 32 | Virtual address to translate |
| start_write | input | 1 | Access is a write |
| dir_root_pfn | input | 20 | Frame number of the directory |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a word write |
| mem_req_addr | output | 32 | Word address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | Walk complete, one cycle |
| fault | output | 1 | Last walk hit a non-present entry |
| fill_large | output | 1 | Last walk ended at a 4 MB mapping |
| fill_paddr | output | 32 | Translated physical address |
| fill_entry | output | 32 | Final entry after flag update |

## Verification
The assertions assume a memory that honours the handshake. It raises `mem_rsp_valid` exactly once per accepted read and never for a write, and only after that read has been accepted. They also assume that a write counts as complete on the cycle it is accepted. The bench memory model follows these rules: it answers each read once, after 0 to 2 idle cycles, and toggles `mem_req_ready` in a pseudo-random pattern so that requests are held across stalls. The bench presents `start_valid` only while `start_ready` is high, and it keeps the root frame constant.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int unsigned BIT_PRESENT  = 0;
   localparam int unsigned BIT_ACCESSED = 5;
   localparam int unsigned BIT_DIRTY    = 6;
   localparam int unsigned BIT_BIGPAGE  = 7;

   typedef enum logic [2:0] {
      S_IDLE,
      S_L1_REQ,
      S_L1_WAIT,
      S_L1_WB,
      S_L2_REQ,
      S_L2_WAIT,
      S_L2_WB,
      S_FIN
   } walk_state_t;
endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned OFF_W  = 12,
   parameter bit          BIG_EN = 1'b1
) (
   input  logic [ADDR_W-1:0]       vaddr,
   input  logic [ADDR_W-OFF_W-1:0] root_pfn,
   input  logic [ADDR_W-OFF_W-1:0] dir_pfn,
   input  logic                    dir_big_bit,
   input  logic [ADDR_W-OFF_W-1:0] leaf_pfn,
   output logic [ADDR_W-1:0]       dir_addr,
   output logic [ADDR_W-1:0]       tbl_addr,
   output logic [ADDR_W-1:0]       small_pa,
   output logic [ADDR_W-1:0]       big_pa,
   output logic                    is_big
);
   localparam int unsigned PFN_W     = ADDR_W - OFF_W;
   localparam int unsigned BIG_OFF_W = OFF_W + IDX_W;
   localparam int unsigned WORD_LG   = OFF_W - IDX_W;

   if (ADDR_W != 2 * IDX_W + OFF_W) begin : g_bad_split
      $error("ptw_addr_calc: ADDR_W must equal two indices plus the offset");
   end
   if (WORD_LG != 2) begin : g_bad_word
      $error("ptw_addr_calc: a table must fill one page with 4-byte entries");
   end

   assign dir_addr = {root_pfn, vaddr[ADDR_W-1 -: IDX_W], {WORD_LG{1'b0}}};
   assign tbl_addr = {dir_pfn, vaddr[OFF_W +: IDX_W], {WORD_LG{1'b0}}};
   assign small_pa = {leaf_pfn, vaddr[OFF_W-1:0]};
   assign big_pa   = {dir_pfn[PFN_W-1:IDX_W], vaddr[BIG_OFF_W-1:0]};

   if (BIG_EN) begin : g_big
      assign is_big = dir_big_bit;
   end else begin : g_no_big
      assign is_big = 1'b0;
   end
endmodule

// File: rtl/ptw_flag_merge.sv
module ptw_flag_merge import ptw_pkg::*; #(
   parameter int unsigned ENT_W = 32
) (
   input  logic [ENT_W-1:0] entry_in,
   input  logic             mark_dirty,
   output logic [ENT_W-1:0] entry_out,
   output logic             changed
);
   if (ENT_W <= BIT_BIGPAGE) begin : g_bad_width
      $error("ptw_flag_merge: entry too narrow for the flag bits");
   end

   always_comb begin
      entry_out = entry_in;
      entry_out[BIT_ACCESSED] = 1'b1;
      if (mark_dirty) entry_out[BIT_DIRTY] = 1'b1;
   end

   assign changed = (entry_out != entry_in);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned OFF_W  = 12,
   parameter bit          BIG_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_valid,
   output logic                    start_ready,
   input  logic [ADDR_W-1:0]       start_vaddr,
   input  logic                    start_write,
   input  logic [ADDR_W-OFF_W-1:0] dir_root_pfn,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic                    mem_req_write,
   output logic [ADDR_W-1:0]       mem_req_addr,
   output logic [ADDR_W-1:0]       mem_req_wdata,
   input  logic                    mem_rsp_valid,
   input  logic [ADDR_W-1:0]       mem_rsp_rdata,
   output logic                    done,
   output logic                    fault,
   output logic                    fill_large,
   output logic [ADDR_W-1:0]       fill_paddr,
   output logic [ADDR_W-1:0]       fill_entry
);
   localparam int unsigned PFN_W  = ADDR_W - OFF_W;
   localparam int unsigned ENT_W  = ADDR_W;
   localparam int unsigned LEVELS = 2;

   walk_state_t       st;
   logic [ADDR_W-1:0] va_q;
   logic              wr_q;
   logic [PFN_W-1:0]  root_q;
   logic [ENT_W-1:0]  pde_q, pte_q;

   logic [ENT_W-1:0]  lvl_ent  [LEVELS];
   logic [ENT_W-1:0]  lvl_new  [LEVELS];
   logic              lvl_mark [LEVELS];
   logic              lvl_chg  [LEVELS];

   logic [ADDR_W-1:0] dir_addr, tbl_addr, small_pa, big_pa;
   logic              is_big;

   // Entry under inspection: live read data while waiting, stored copy otherwise.
   assign lvl_ent[0]  = (st == S_L1_WAIT) ? mem_rsp_rdata : pde_q;
   assign lvl_ent[1]  = (st == S_L2_WAIT) ? mem_rsp_rdata : pte_q;
   assign lvl_mark[0] = wr_q & is_big;
   assign lvl_mark[1] = wr_q;

   ptw_addr_calc #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .BIG_EN(BIG_EN)
   ) u_calc (
      .vaddr      (va_q),
      .root_pfn   (root_q),
      .dir_pfn    (lvl_ent[0][ADDR_W-1:OFF_W]),
      .dir_big_bit(lvl_ent[0][BIT_BIGPAGE]),
      .leaf_pfn   (lvl_ent[1][ADDR_W-1:OFF_W]),
      .dir_addr   (dir_addr),
      .tbl_addr   (tbl_addr),
      .small_pa   (small_pa),
      .big_pa     (big_pa),
      .is_big     (is_big)
   );

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      ptw_flag_merge #(.ENT_W(ENT_W)) u_merge (
         .entry_in  (lvl_ent[g]),
         .mark_dirty(lvl_mark[g]),
         .entry_out (lvl_new[g]),
         .changed   (lvl_chg[g])
      );
   end

   assign start_ready   = (st == S_IDLE);
   assign done          = (st == S_FIN);
   assign mem_req_valid = (st == S_L1_REQ) || (st == S_L1_WB) ||
                          (st == S_L2_REQ) || (st == S_L2_WB);
   assign mem_req_write = (st == S_L1_WB) || (st == S_L2_WB);

   always_comb begin
      mem_req_addr  = '0;
      mem_req_wdata = '0;
      case (st)
         S_L1_REQ: mem_req_addr = dir_addr;
         S_L1_WB: begin
            mem_req_addr  = dir_addr;
            mem_req_wdata = lvl_new[0];
         end
         S_L2_REQ: mem_req_addr = tbl_addr;
         S_L2_WB: begin
            mem_req_addr  = tbl_addr;
            mem_req_wdata = lvl_new[1];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         va_q       <= '0;
         wr_q       <= 1'b0;
         root_q     <= '0;
         pde_q      <= '0;
         pte_q      <= '0;
         fault      <= 1'b0;
         fill_large <= 1'b0;
         fill_paddr <= '0;
         fill_entry <= '0;
      end else begin
         case (st)
            S_IDLE: if (start_valid) begin
               va_q   <= start_vaddr;
               wr_q   <= start_write;
               root_q <= dir_root_pfn;
               st     <= S_L1_REQ;
            end
            S_L1_REQ: if (mem_req_ready) st <= S_L1_WAIT;
            S_L1_WAIT: if (mem_rsp_valid) begin
               pde_q <= mem_rsp_rdata;
               if (!mem_rsp_rdata[BIT_PRESENT]) begin
                  fault      <= 1'b1;
                  fill_large <= 1'b0;
                  fill_paddr <= '0;
                  fill_entry <= mem_rsp_rdata;
                  st         <= S_FIN;
               end else if (lvl_chg[0]) begin
                  st <= S_L1_WB;
               end else if (is_big) begin
                  fault      <= 1'b0;
                  fill_large <= 1'b1;
                  fill_paddr <= big_pa;
                  fill_entry <= lvl_new[0];
                  st         <= S_FIN;
               end else begin
                  st <= S_L2_REQ;
               end
            end
            S_L1_WB: if (mem_req_ready) begin
               if (is_big) begin
                  fault      <= 1'b0;
                  fill_large <= 1'b1;
                  fill_paddr <= big_pa;
                  fill_entry <= lvl_new[0];
                  st         <= S_FIN;
               end else begin
                  st <= S_L2_REQ;
               end
            end
            S_L2_REQ: if (mem_req_ready) st <= S_L2_WAIT;
            S_L2_WAIT: if (mem_rsp_valid) begin
               pte_q <= mem_rsp_rdata;
               if (!mem_rsp_rdata[BIT_PRESENT]) begin
                  fault      <= 1'b1;
                  fill_large <= 1'b0;
                  fill_paddr <= '0;
                  fill_entry <= mem_rsp_rdata;
                  st         <= S_FIN;
               end else if (lvl_chg[1]) begin
                  st <= S_L2_WB;
               end else begin
                  fault      <= 1'b0;
                  fill_large <= 1'b0;
                  fill_paddr <= small_pa;
                  fill_entry <= lvl_new[1];
                  st         <= S_FIN;
               end
            end
            S_L2_WB: if (mem_req_ready) begin
               fault      <= 1'b0;
               fill_large <= 1'b0;
               fill_paddr <= small_pa;
               fill_entry <= lvl_new[1];
               st         <= S_FIN;
            end
            S_FIN: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   logic [ADDR_W-1:0] chk_rd_addr;
   always_ff @(posedge clk) begin
      if (!rst_n) chk_rd_addr <= '0;
      else if (mem_req_valid && mem_req_ready && !mem_req_write) chk_rd_addr <= mem_req_addr;
   end

   a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_write) && $stable(mem_req_wdata));

   a_r6_wb_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> mem_req_wdata[BIT_ACCESSED]);

   a_r6_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> mem_req_addr == chk_rd_addr);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_results_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(fill_paddr) && $stable(fill_entry) && $stable(fault) && $stable(fill_large));

   a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start_ready |-> !mem_req_valid);

   a_r3_fault_entry: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault |-> !fill_entry[BIT_PRESENT] && !fill_large);

   a_r5_large_entry: assert property (@(posedge clk) disable iff (!rst_n)
      done && fill_large |-> fill_entry[BIT_BIGPAGE] && fill_entry[BIT_ACCESSED]);
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
   localparam logic [19:0] ROOT = 20'h00010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_valid = 1'b0;
   logic        start_ready;
   logic [31:0] start_vaddr = '0;
   logic        start_write = 1'b0;
   logic        mem_req_valid, mem_req_ready, mem_req_write;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_rdata;
   logic        done, fault, fill_large;
   logic [31:0] fill_paddr, fill_entry;

   always #2.5 clk = ~clk;

   ptw_walker uut (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_ready(start_ready),
      .start_vaddr(start_vaddr), .start_write(start_write),
      .dir_root_pfn(ROOT),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .done(done), .fault(fault), .fill_large(fill_large),
      .fill_paddr(fill_paddr), .fill_entry(fill_entry)
   );

   typedef struct {
      logic        fault;
      logic        big;
      logic [31:0] pa;
      logic [31:0] ent;
   } exp_t;

   typedef struct {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] data;
      string       tag;
   } acc_t;

   exp_t        exp_q[$];
   acc_t        acc_q[$];
   logic [31:0] mem [logic [31:0]];
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          finished = 1'b0;

   function automatic logic [31:0] rd(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Reference walk built from the requirements; records expected accesses.
   function automatic exp_t model(logic [31:0] va, logic wr);
      exp_t e;
      logic [31:0] da, d, nd, ta, t, nt;
      e.fault = 1'b0; e.big = 1'b0; e.pa = '0; e.ent = '0;
      da = {ROOT, va[31:22], 2'b00};
      acc_q.push_back('{1'b0, da, 32'h0, "R1"});
      d = rd(da);
      if (!d[0]) begin e.fault = 1'b1; e.ent = d; return e; end
      if (d[7]) begin
         nd = d | 32'h20 | (wr ? 32'h40 : 32'h0);
         if (nd != d) acc_q.push_back('{1'b1, da, nd, (wr && !d[6]) ? "R7" : "R6"});
         e.big = 1'b1; e.pa = {d[31:22], va[21:0]}; e.ent = nd;
         return e;
      end
      nd = d | 32'h20;
      if (nd != d) acc_q.push_back('{1'b1, da, nd, "R6"});
      ta = {d[31:12], va[21:12], 2'b00};
      acc_q.push_back('{1'b0, ta, 32'h0, "R2"});
      t = rd(ta);
      if (!t[0]) begin e.fault = 1'b1; e.ent = t; return e; end
      nt = t | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (nt != t) acc_q.push_back('{1'b1, ta, nt, (wr && !t[6]) ? "R7" : "R6"});
      e.pa = {t[31:12], va[11:0]}; e.ent = nt;
      return e;
   endfunction

   // Memory model: random ready, 0..2 cycle read latency, checks each access.
   initial begin
      logic [7:0]  lfsr = 8'hA5;
      bit          xfer = 1'b0, stall = 1'b0, pend = 1'b0;
      logic        x_wr = 1'b0;
      logic [31:0] x_addr = '0, x_data = '0, s_addr = '0, p_addr = '0;
      int          lat = 0;
      acc_t        a;
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (pend) begin
            if (lat == 0) begin
               mem_rsp_valid = 1'b1; mem_rsp_rdata = rd(p_addr); pend = 1'b0;
            end else lat--;
         end
         if (xfer) begin
            if (acc_q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R3/R8: unexpected access addr %h wr %0d, expected none", x_addr, x_wr);
            end else begin
               a = acc_q.pop_front();
               chk(a.tag, {31'h0, x_wr}, {31'h0, a.wr});
               chk(a.tag, x_addr, a.addr);
               if (a.wr) chk(a.tag, x_data, a.data);
            end
            if (x_wr) mem[x_addr] = x_data;
            else begin pend = 1'b1; p_addr = x_addr; lat = int'(lfsr[2:1]) % 3; end
         end
         if (stall) begin
            chk("R11", {31'h0, mem_req_valid}, 32'h1);
            chk("R11", mem_req_addr, s_addr);
         end
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         mem_req_ready = lfsr[0] | lfsr[3];
         xfer  = mem_req_valid && mem_req_ready;
         stall = mem_req_valid && !mem_req_ready;
         x_wr = mem_req_write; x_addr = mem_req_addr; x_data = mem_req_wdata;
         s_addr = mem_req_addr;
      end
   end

   // Monitor: compare each completed walk against the scoreboard head.
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (done) begin
            if (exp_q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R10: done with no walk pending, actual 1 expected 0");
            end else begin
               e = exp_q.pop_front();
               chk("R3", {31'h0, fault}, {31'h0, e.fault});
               chk(e.big ? "R5" : "R4", fill_paddr, e.pa);
               chk("R9", fill_entry, e.ent);
               if (!e.fault) chk("R5", {31'h0, fill_large}, {31'h0, e.big});
            end
         end
      end
   end

   task automatic walk(input logic [31:0] va, input logic wr);
      logic [31:0] fp, fe;
      logic        ff;
      int          k;
      exp_q.push_back(model(va, wr));
      @(negedge clk);
      chk("R12", {31'h0, start_ready}, 32'h1);
      start_vaddr = va; start_write = wr; start_valid = 1'b1;
      @(negedge clk);
      start_valid = 1'b0;
      chk("R12", {31'h0, start_ready}, 32'h0);
      k = 0;
      do begin @(negedge clk); k++; end while (!done && k < 400);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R10: walk timeout, actual done 0 expected 1");
         return;
      end
      fp = fill_paddr; fe = fill_entry; ff = fault;
      @(negedge clk);
      chk("R10", {31'h0, done}, 32'h0);
      repeat (3) @(negedge clk);
      chk("R10", fill_paddr, fp);
      chk("R10", fill_entry, fe);
      chk("R10", {31'h0, fault}, {31'h0, ff});
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL R10: watchdog expired, actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // directory slot 1 points at a table at 0x20000; slot 2 maps a 4 MB page
      mem[32'h0001_0004] = 32'h0002_0003;
      mem[32'h0002_000C] = 32'h0ABC_D117;
      mem[32'h0002_0014] = 32'h1234_5000;
      mem[32'h0001_0008] = 32'h0C00_0081;
      for (int i = 0; i < 6; i++) begin
         logic [31:0] da, ta;
         da = {ROOT, 10'(16 + i), 2'b00};
         if (i == 4) mem[da] = {10'(32'h100 + i), 22'h0} | 32'h0000_0081;
         else mem[da] = {20'(32'h40 + i), 12'h000} | (i[0] ? 32'h23 : 32'h03);
         ta = {20'(32'h40 + i), 10'(i * 7), 2'b00};
         mem[ta] = {20'(32'h500 + i), 12'h000} | (i == 2 ? 32'h0 : 32'h1) |
                   (i == 3 ? 32'h60 : 32'h0) | 32'h10E;
      end

      repeat (4) @(negedge clk);
      chk("R12", {31'h0, start_ready}, 32'h1);
      chk("R10", {31'h0, done}, 32'h0);
      chk("R11", {31'h0, mem_req_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12", {31'h0, start_ready}, 32'h1);
      chk("R3", {31'h0, fault}, 32'h0);

      walk(32'h0040_3123, 1'b0);   // R1 R2 R4 R6: both accessed flags set
      walk(32'h0040_3123, 1'b1);   // R7: dirty only on the leaf
      walk(32'h0040_3123, 1'b1);   // R8: no write-back at all
      walk(32'h0080_1234, 1'b1);   // R5: large page, no second read
      walk(32'h0080_1234, 1'b0);   // R8: large page already flagged
      walk(32'h00C0_0000, 1'b0);   // R3: directory entry not present
      walk(32'h0040_5000, 1'b1);   // R3: table entry not present
      for (int i = 0; i < 6; i++) begin
         logic [31:0] va;
         va = {10'(16 + i), 10'(i * 7), 12'(i * 32'h111)};
         walk(va, i[0]);
         walk(va, 1'b1);
      end

      repeat (5) @(negedge clk);
      chk("R8", acc_q.size(), 32'h0);
      chk("R10", exp_q.size(), 32'h0);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule